// File: doc/BRIEF.md
# DDR Command Decoder with Bank Tracker

This block sits behind the command pins of a double-data-rate SDRAM model or controller monitor. It samples the chip-select, row-strobe, column-strobe, write-enable, bank and A10 inputs on every rising clock edge and turns them into one decoded command code. It also keeps an open/closed row state for each bank, a per-bank lockout that follows a precharge or an auto-precharge, and the current low-power mode that the clock-enable input selects.

Commands that break the bank rules raise an illegal flag. An illegal command leaves the bank state, the timers and the power mode exactly as they were, so a monitor can count violations while the model keeps running. All results are registered and appear one clock after the edge that sampled them.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With cs_n high the command reads as deselect (code 0), whatever ras_n, cas_n and we_n carry, and the banks do not change.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as 000 mode set (code 2, or 3 when ba bit 0 is 1), 011 activate (4), 101 read (5, or 6 with A10 high), 100 write (7, or 8 with A10 high), 010 precharge (9, or 10 with A10 high), 110 burst stop (11), 001 refresh (12), 111 no-op (1).
- R3: An activate opens the bank given by ba (bit i of bank_open_o is bank i); an activate to an open bank is illegal.
- R4: A read or write to a closed bank is illegal.
- R5: Precharge with A10 low closes bank ba and with A10 high closes every open bank; each bank it closes is locked for TRP cycles (a command to it at edge n+TRP is accepted). Precharge of a closed, unlocked bank is legal and changes nothing.
- R6: A mode set is illegal while any bank is open or locked; after a precharge at edge n it is accepted at edge n+TRP.
- R7: Read or write with auto-precharge at edge n closes the bank; any command to it before edge n+BL/2+TRP is illegal, and one at that edge is accepted.
- R8: An illegal command changes no bank state and no power mode.
- R9: CKE falling with a no-op or deselect enters precharge power-down (mode_o 1) when all banks are closed, else active power-down (mode_o 2); any other command except refresh on a falling CKE is illegal.
- R10: Refresh with CKE high is illegal while a bank is open or locked; refresh on a falling CKE reads as code 13 and enters self refresh (mode_o 3) under the same condition, else it is illegal.
- R11: While the previous CKE sample is low the inputs are ignored, the command reads 0, and CKE high returns mode_o to 0.
- R12: After reset all banks are closed and unlocked, mode_o is 0, cmd_o is 0 and illegal_o is 0; every result appears one clock after its sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW | Bank select |
| a10 | input | 1 | All-bank / auto-precharge qualifier |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | Command broke a bank or timing rule |
| bank_open_o | output | NBANK | Open-row state per bank |
| mode_o | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
Every output is one register away from the sampling edge, so the bench drives each command on a falling edge and compares cmd_o, illegal_o, bank_open_o and mode_o one nanosecond after the next rising edge. Lockout windows are counted in those edges: a lock made at edge n is probed at the last blocked edge and at the first free edge (n+TRP-1 and n+TRP for precharge, n+BL/2+TRP-1 and n+BL/2+TRP for auto-precharge). Low-power entry and exit are checked on the edge where CKE changes and on the edge after, where the inputs must be ignored.

// File: rtl/ddr_ct_pkg.sv
package ddr_ct_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_MRS   = 4'd2,
    CMD_EMRS  = 4'd3,
    CMD_ACT   = 4'd4,
    CMD_RD    = 4'd5,
    CMD_RDA   = 4'd6,
    CMD_WR    = 4'd7,
    CMD_WRA   = 4'd8,
    CMD_PRE   = 4'd9,
    CMD_PREA  = 4'd10,
    CMD_BST   = 4'd11,
    CMD_REF   = 4'd12,
    CMD_SREF  = 4'd13
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_PPD  = 2'd1,
    MODE_APD  = 2'd2,
    MODE_SREF = 2'd3
  } mode_e;
endpackage

// File: rtl/ddr_ct_rst_sync.sv
module ddr_ct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ddr_ct_decode.sv
module ddr_ct_decode
  import ddr_ct_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  input  logic a10,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_DESEL;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = ba0 ? CMD_EMRS : CMD_MRS;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b110:  cmd = CMD_BST;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/ddr_ct_bank.sv
module ddr_ct_bank #(
  parameter int TW         = 3,
  parameter int SHORT_LOCK = 3,
  parameter int LONG_LOCK  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic pre_req,
  input  logic auto_req,
  output logic is_open,
  output logic locked
);
  localparam logic [TW-1:0] SHORT_LOAD = TW'(SHORT_LOCK - 1);
  localparam logic [TW-1:0] LONG_LOAD  = TW'(LONG_LOCK - 1);

  logic          open_q, open_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          en;

  always_comb begin
    open_d = open_q;
    tmr_d  = tmr_q;
    if (open_req) begin
      open_d = 1'b1;
    end else if (pre_req) begin
      open_d = 1'b0;
      tmr_d  = SHORT_LOAD;
    end else if (auto_req) begin
      open_d = 1'b0;
      tmr_d  = LONG_LOAD;
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  assign en = open_req | pre_req | auto_req | (tmr_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else if (en) begin
      open_q <= open_d;
      tmr_q  <= tmr_d;
    end
  end

  assign is_open = open_q;
  assign locked  = (tmr_q != '0);
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_ct_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BL    = 4,
  parameter int TRP   = 3,
  localparam int BAW  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BAW-1:0]   ba,
  input  logic             a10,
  output logic [3:0]       cmd_o,
  output logic             illegal_o,
  output logic [NBANK-1:0] bank_open_o,
  output logic [1:0]       mode_o
);
  localparam int LONG_LOCK = BL / 2 + TRP;
  localparam int TW        = $clog2(LONG_LOCK + 1);

  logic             rst_s_n;
  cmd_e             cur;
  logic [NBANK-1:0] open_vec, lock_vec, sel;
  logic [NBANK-1:0] open_req, pre_req, auto_req;
  logic             cke_q;
  cmd_e             cmd_q, cmd_d;
  logic             ill_q, ill_d;
  mode_e            mode_q, mode_d;
  logic             any_open, any_lock, tgt_open, tgt_lock, cke_fall;

  ddr_ct_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  ddr_ct_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba0(ba[0]), .a10(a10), .cmd(cur)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_ct_bank #(.TW(TW), .SHORT_LOCK(TRP), .LONG_LOCK(LONG_LOCK)) u_bank (
      .clk(clk), .rst_n(rst_s_n),
      .open_req(open_req[b]), .pre_req(pre_req[b]), .auto_req(auto_req[b]),
      .is_open(open_vec[b]), .locked(lock_vec[b])
    );
  end

  assign sel      = NBANK'(1) << ba;
  assign any_open = |open_vec;
  assign any_lock = |lock_vec;
  assign tgt_open = |(open_vec & sel);
  assign tgt_lock = |(lock_vec & sel);
  assign cke_fall = cke_q & ~cke;

  // Legality, power mode and bank operations for the sampled command
  always_comb begin
    cmd_d    = CMD_DESEL;
    ill_d    = 1'b0;
    mode_d   = mode_q;
    open_req = '0;
    pre_req  = '0;
    auto_req = '0;
    if (!cke_q) begin
      if (cke) mode_d = MODE_RUN;
    end else begin
      cmd_d = cur;
      unique case (cur)
        CMD_ACT:                        ill_d = tgt_open | tgt_lock;
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: ill_d = ~tgt_open | tgt_lock;
        CMD_PRE:                        ill_d = tgt_lock;
        CMD_PREA:                       ill_d = any_lock;
        CMD_MRS, CMD_EMRS, CMD_REF:     ill_d = any_open | any_lock;
        default:                        ill_d = 1'b0;
      endcase
      if (cke_fall) begin
        unique case (cur)
          CMD_DESEL, CMD_NOP: mode_d = any_open ? MODE_APD : MODE_PPD;
          CMD_REF: begin
            cmd_d = CMD_SREF;
            if (!ill_d) mode_d = MODE_SREF;
          end
          default: ill_d = 1'b1;
        endcase
      end
      if (!ill_d) begin
        unique case (cur)
          CMD_ACT:          open_req = sel;
          CMD_RDA, CMD_WRA: auto_req = sel;
          CMD_PRE:          pre_req  = sel & open_vec;
          CMD_PREA:         pre_req  = open_vec;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_DESEL;
      ill_q  <= 1'b0;
      mode_q <= MODE_RUN;
    end else begin
      cke_q  <= cke;
      cmd_q  <= cmd_d;
      ill_q  <= ill_d;
      mode_q <= mode_d;
    end
  end

  assign cmd_o       = cmd_q;
  assign illegal_o   = ill_q;
  assign bank_open_o = open_vec;
  assign mode_o      = mode_q;
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
  parameter int NBANK = 4,
  parameter int BAW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BAW-1:0]   ba,
  input logic [3:0]       cmd_o,
  input logic             illegal_o,
  input logic [NBANK-1:0] bank_open_o,
  input logic [1:0]       mode_o
);
  // R1 / R11: ignored or deselected cycles leave the banks alone
  p_desel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd0) |-> $stable(bank_open_o));

  // R8: a flagged command changes no bank state
  p_illegal_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(bank_open_o));

  // R3: an accepted activate leaves its bank open
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd4 && !illegal_o) |-> bank_open_o[$past(ba)]);

  // R7: an accepted auto-precharge leaves its bank closed
  p_auto_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == 4'd6 || cmd_o == 4'd8) && !illegal_o) |-> !bank_open_o[$past(ba)]);

  // R6: an accepted mode set saw every bank closed
  p_mrs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == 4'd2 || cmd_o == 4'd3) && !illegal_o) |-> ($past(bank_open_o) == '0));

  // R9: precharge power-down only with every bank closed
  p_ppd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (bank_open_o == '0));

  // R10: self refresh only with every bank closed
  p_sref_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3) |-> (bank_open_o == '0));

  // R8: a flagged command keeps the power mode
  p_illegal_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(mode_o));
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(.NBANK(NBANK), .BAW(BAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ba(ba), .cmd_o(cmd_o), .illegal_o(illegal_o),
  .bank_open_o(bank_open_o), .mode_o(mode_o)
);

// File: tb/ddr_cmd_tracker_bench.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_bench;
  localparam int NV = 42;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmd_o;
  logic       illegal_o;
  logic [3:0] bank_open_o;
  logic [1:0] mode_o;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  ddr_cmd_tracker #(.NBANK(4), .BL(4), .TRP(3)) u_ddr_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .bank_open_o(bank_open_o), .mode_o(mode_o)
  );

  // {req, cke, cs_n, ras/cas/we, ba, a10, exp_cmd, exp_ill, exp_open, exp_mode}
  localparam logic [22:0] VEC [NV] = '{
    {4'd3, 1'b1,1'b0,3'b011,2'd0,1'b0, 4'd4, 1'b0,4'b0001,2'd0}, // R3 open b0
    {4'd3, 1'b1,1'b0,3'b011,2'd0,1'b0, 4'd4, 1'b1,4'b0001,2'd0}, // R3 reopen
    {4'd4, 1'b1,1'b0,3'b101,2'd1,1'b0, 4'd5, 1'b1,4'b0001,2'd0}, // R4 read idle
    {4'd3, 1'b1,1'b0,3'b011,2'd2,1'b0, 4'd4, 1'b0,4'b0101,2'd0}, // R3 open b2
    {4'd2, 1'b1,1'b0,3'b100,2'd2,1'b0, 4'd7, 1'b0,4'b0101,2'd0}, // R2 write
    {4'd6, 1'b1,1'b0,3'b000,2'd0,1'b0, 4'd2, 1'b1,4'b0101,2'd0}, // R6 mrs open
    {4'd7, 1'b1,1'b0,3'b101,2'd0,1'b1, 4'd6, 1'b0,4'b0100,2'd0}, // R7 rda b0 (n)
    {4'd2, 1'b1,1'b0,3'b110,2'd0,1'b0, 4'd11,1'b0,4'b0100,2'd0}, // R2 burst stop
    {4'd7, 1'b1,1'b0,3'b011,2'd0,1'b0, 4'd4, 1'b1,4'b0100,2'd0}, // R7 n+2
    {4'd1, 1'b1,1'b1,3'b011,2'd0,1'b0, 4'd0, 1'b0,4'b0100,2'd0}, // R1 deselect
    {4'd7, 1'b1,1'b0,3'b011,2'd0,1'b0, 4'd4, 1'b1,4'b0100,2'd0}, // R7 n+4
    {4'd7, 1'b1,1'b0,3'b011,2'd0,1'b0, 4'd4, 1'b0,4'b0101,2'd0}, // R7 n+5 free
    {4'd5, 1'b1,1'b0,3'b010,2'd0,1'b1, 4'd10,1'b0,4'b0000,2'd0}, // R5 prea (m)
    {4'd6, 1'b1,1'b0,3'b000,2'd0,1'b0, 4'd2, 1'b1,4'b0000,2'd0}, // R6 m+1
    {4'd6, 1'b1,1'b0,3'b000,2'd1,1'b0, 4'd3, 1'b1,4'b0000,2'd0}, // R6 emrs m+2
    {4'd6, 1'b1,1'b0,3'b000,2'd0,1'b0, 4'd2, 1'b0,4'b0000,2'd0}, // R6 m+3 free
    {4'd10,1'b1,1'b0,3'b001,2'd0,1'b0, 4'd12,1'b0,4'b0000,2'd0}, // R10 refresh
    {4'd3, 1'b1,1'b0,3'b011,2'd3,1'b0, 4'd4, 1'b0,4'b1000,2'd0}, // R3 open b3
    {4'd5, 1'b1,1'b0,3'b010,2'd1,1'b0, 4'd9, 1'b0,4'b1000,2'd0}, // R5 pre idle
    {4'd5, 1'b1,1'b0,3'b010,2'd3,1'b0, 4'd9, 1'b0,4'b0000,2'd0}, // R5 pre b3
    {4'd5, 1'b1,1'b0,3'b011,2'd3,1'b0, 4'd4, 1'b1,4'b0000,2'd0}, // R5 locked
    {4'd9, 1'b0,1'b0,3'b111,2'd0,1'b0, 4'd1, 1'b0,4'b0000,2'd1}, // R9 ppd
    {4'd11,1'b0,1'b0,3'b011,2'd3,1'b0, 4'd0, 1'b0,4'b0000,2'd1}, // R11 ignored
    {4'd11,1'b1,1'b0,3'b111,2'd0,1'b0, 4'd0, 1'b0,4'b0000,2'd0}, // R11 exit
    {4'd3, 1'b1,1'b0,3'b011,2'd1,1'b0, 4'd4, 1'b0,4'b0010,2'd0}, // R3 open b1
    {4'd9, 1'b0,1'b0,3'b111,2'd0,1'b0, 4'd1, 1'b0,4'b0010,2'd2}, // R9 apd
    {4'd11,1'b1,1'b0,3'b111,2'd0,1'b0, 4'd0, 1'b0,4'b0010,2'd0}, // R11 exit
    {4'd10,1'b0,1'b0,3'b001,2'd0,1'b0, 4'd13,1'b1,4'b0010,2'd0}, // R10 sref open
    {4'd11,1'b1,1'b0,3'b111,2'd0,1'b0, 4'd0, 1'b0,4'b0010,2'd0}, // R11 exit
    {4'd5, 1'b1,1'b0,3'b010,2'd1,1'b0, 4'd9, 1'b0,4'b0000,2'd0}, // R5 pre b1 (k)
    {4'd2, 1'b1,1'b0,3'b111,2'd0,1'b0, 4'd1, 1'b0,4'b0000,2'd0}, // R2 no-op
    {4'd10,1'b1,1'b0,3'b001,2'd0,1'b0, 4'd12,1'b1,4'b0000,2'd0}, // R10 k+2 locked
    {4'd10,1'b0,1'b0,3'b001,2'd0,1'b0, 4'd13,1'b0,4'b0000,2'd3}, // R10 sref
    {4'd11,1'b0,1'b1,3'b000,2'd0,1'b0, 4'd0, 1'b0,4'b0000,2'd3}, // R11 held
    {4'd11,1'b1,1'b0,3'b111,2'd0,1'b0, 4'd0, 1'b0,4'b0000,2'd0}, // R11 exit
    {4'd3, 1'b1,1'b0,3'b011,2'd1,1'b0, 4'd4, 1'b0,4'b0010,2'd0}, // R3 open b1
    {4'd7, 1'b1,1'b0,3'b100,2'd1,1'b1, 4'd8, 1'b0,4'b0000,2'd0}, // R7 wra (w)
    {4'd9, 1'b0,1'b0,3'b011,2'd2,1'b0, 4'd4, 1'b1,4'b0000,2'd0}, // R9 act on fall
    {4'd11,1'b1,1'b0,3'b111,2'd0,1'b0, 4'd0, 1'b0,4'b0000,2'd0}, // R11 exit
    {4'd7, 1'b1,1'b0,3'b011,2'd1,1'b0, 4'd4, 1'b1,4'b0000,2'd0}, // R7 w+3
    {4'd8, 1'b1,1'b0,3'b011,2'd1,1'b0, 4'd4, 1'b1,4'b0000,2'd0}, // R8 w+4
    {4'd7, 1'b1,1'b0,3'b011,2'd1,1'b0, 4'd4, 1'b0,4'b0010,2'd0}  // R7 w+5 free
  };

  task automatic check(input string req, input logic [3:0] c, input logic il,
                       input logic [3:0] op, input logic [1:0] md);
    checks++;
    if (cmd_o !== c || illegal_o !== il || bank_open_o !== op || mode_o !== md) begin
      errors++;
      $display("FAIL %s: cmd=%0d ill=%0b open=%b mode=%0d, expected cmd=%0d ill=%0b open=%b mode=%0d",
               req, cmd_o, illegal_o, bank_open_o, mode_o, c, il, op, md);
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R12 reset", 4'd0, 1'b0, 4'b0000, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R12 after release", 4'd0, 1'b0, 4'b0000, 2'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cke, cs_n, ras_n, cas_n, we_n, ba, a10} = VEC[i][18:11];
      @(posedge clk);
      #1 check($sformatf("R%0d vector %0d", VEC[i][22:19], i), VEC[i][10:7],
               VEC[i][6], VEC[i][5:2], VEC[i][1:0]);
    end

    // R12: asynchronous reset clears an open bank at once
    @(negedge clk);
    {cke, cs_n, ras_n, cas_n, we_n, ba, a10} = {1'b1, 1'b0, 3'b011, 2'd3, 1'b0};
    @(posedge clk);
    #1 check("R3 open b3 before reset", 4'd4, 1'b0, 4'b1010, 2'd0);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    rst_n = 1'b0;
    #1 check("R12 reset mid-run", 4'd0, 1'b0, 4'b0000, 2'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R12 idle after second release", 4'd0, 1'b0, 4'b0000, 2'd0);

    // R6: mode set on a freshly reset device is accepted
    @(negedge clk);
    {cke, cs_n, ras_n, cas_n, we_n, ba, a10} = {1'b1, 1'b0, 3'b000, 2'd1, 1'b0};
    @(posedge clk);
    #1 check("R6 emrs after reset", 4'd3, 1'b0, 4'b0000, 2'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule